// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Dirty-Page Check

This block holds recently used page translations in a four-way, thirty-two-set array. Each lookup takes a virtual page number, an address-space identifier, a write flag and a privilege flag. The set is chosen by the low bits of the page number, and all ways of that set are compared in parallel. The block reports exactly one of four outcomes:

- a completed translation, with the physical page and its attributes;
- a miss;
- a protection fault;
- an initial-page-write fault, raised when a permitted write reaches a page that has never been marked as written.

Every outcome except a miss also reports which way matched. Software records that way and later names it as the refill target.

Refills come from a staged entry in two words. The high word carries the page number and the address-space identifier. The low word carries the physical page and the attribute bits. A one-cycle load command copies both words into the way selected by software, at the set given by the staged page number. Lookups are combinational from the stored array, so the next cycle already sees a loaded entry.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, so any lookup in any set reports a miss.
- R2: When `ld_en` is high at a rising clock edge, the staged words are stored in way `ld_way` of set `ld_hi[ASID_W +: IDX_W]`. A lookup in the following cycle sees the stored entry.
- R3: A lookup matches a way when all of these hold: the entry is valid (`ld_lo[0]`), its page number equals `lk_vpn`, and either its ASID equals `lk_asid` or its shared bit (`ld_lo[1]`) is set. A permitted read, or a permitted write to an entry whose dirty bit (`ld_lo[2]`) is 1, reports `res_hit`. It also outputs the way, the PPN (`ld_lo[26:7]`), the size bit (`ld_lo[4]`) and the cacheable bit (`ld_lo[3]`).
- R4: When no way matches, only `res_miss` is raised, and `res_way` and `res_ppn` are 0.
- R5: An ASID mismatch on a non-shared entry is a miss. A shared entry matches whatever the ASID.
- R6: The rights field `ld_lo[6:5]` works as follows. Bit 1 set allows user access; privileged access is always allowed. Bit 0 set allows writes. A match that breaks these rules raises `res_prot` and reports the way.
- R7: A permitted write that matches an entry whose dirty bit is 0 raises `res_ipw`, reports the matching way, and does not raise `res_hit`.
- R8: When a write both breaks the rights rules and targets a clean entry, `res_prot` is raised and `res_ipw` is not.
- R9: A load changes only the addressed way and set. Reloading a location replaces its previous entry, and loading an entry with the valid bit at 0 removes it from matching.
- R10: The four outcome flags are mutually exclusive. Exactly one is high while `lk_valid` is high, and all are 0 while it is low.
- R11: When several ways of a set match, the lowest-numbered way is the one reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load the staged entry this cycle |
| ld_way | input | 2 | Software-selected target way for the load |
| ld_hi | input | 28 | Staged high word: {VPN[19:0], ASID[7:0]} |
| ld_lo | input | 27 | Staged low word: {PPN[19:0], rights[1:0], size, cacheable, dirty, shared, valid} |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_write | input | 1 | Lookup is a write |
| lk_priv | input | 1 | Lookup is privileged |
| res_hit | output | 1 | Translation completed |
| res_miss | output | 1 | No way matched |
| res_prot | output | 1 | Access rights violated |
| res_ipw | output | 1 | Permitted write to a clean page |
| res_way | output | 2 | Way that matched (0 on miss) |
| res_ppn | output | 20 | Physical page number on hit, else 0 |
| res_size | output | 1 | Page-size bit on hit, else 0 |
| res_cache | output | 1 | Cacheable bit on hit, else 0 |

## Verification
Every set of every way is filled with a distinct entry. The rights field, dirty bit, shared bit and valid bit of each entry are derived arithmetically from its set and way, so all rights-by-dirty combinations appear in each way. Each entry is then looked up with all four pairs of write and privilege flags. This sweep separates hits, protection faults and initial-page-write faults, and shows that protection wins over the dirty check. A second sweep uses a wrong ASID, which separates shared entries from private ones. Page numbers that are nowhere in the array, overlapping loads of one page into several ways, and a reload with the valid bit cleared exercise the miss path, the lowest-way priority and the replacement behaviour.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Low word layout: {ppn, rights[1:0], size, cacheable, dirty, shared, valid}
  localparam int LO_ATTR_W = 7;
  localparam int LO_VALID  = 0;
  localparam int LO_SHARED = 1;
  localparam int LO_DIRTY  = 2;
  localparam int LO_CACHE  = 3;
  localparam int LO_SIZE   = 4;
  localparam int LO_PR_LO  = 5;

  // rights[1]: user may access; rights[0]: writes allowed
  function automatic logic rights_permit(input logic [1:0] pr, input logic priv,
                                         input logic wr);
    return (priv | pr[1]) & (~wr | pr[0]);
  endfunction

  function automatic logic needs_first_write(input logic wr, input logic dirty);
    return wr & ~dirty;
  endfunction
endpackage

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int SETS = 32,
  parameter int HI_W = 28,
  parameter int LO_W = 27,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [HI_W-1:0]  whi,
  input  logic [LO_W-1:0]  wlo,
  input  logic [IDX_W-1:0] ridx,
  output logic [HI_W-1:0]  rhi,
  output logic [LO_W-1:0]  rlo
);
  logic [HI_W-1:0] hi_mem [SETS];
  logic [LO_W-2:0] lo_mem [SETS];
  logic [SETS-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) begin
      hi_mem[widx] <= whi;
      lo_mem[widx] <= wlo[LO_W-1:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  vld <= '0;
    else if (we) vld[widx] <= wlo[0];
  end

  assign rhi = hi_mem[ridx];
  assign rlo = {lo_mem[ridx], vld[ridx]};
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int WAYS   = 4,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int LO_W   = 27,
  localparam int HI_W  = VPN_W + ASID_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][HI_W-1:0] rd_hi,
  input  logic [WAYS-1:0][LO_W-1:0] rd_lo,
  input  logic [VPN_W-1:0]          q_vpn,
  input  logic [ASID_W-1:0]         q_asid,
  output logic [WAYS-1:0]           way_hit,
  output logic                      any_hit,
  output logic [WAY_W-1:0]          sel_way,
  output logic [LO_W-1:0]           sel_lo
);
  import tlb_pkg::*;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    logic vpn_eq, asid_ok;
    assign vpn_eq  = rd_hi[w][HI_W-1:ASID_W] == q_vpn;
    assign asid_ok = rd_lo[w][LO_SHARED] | (rd_hi[w][ASID_W-1:0] == q_asid);
    assign way_hit[w] = rd_lo[w][LO_VALID] & vpn_eq & asid_ok;
  end

  // lowest-numbered matching way wins
  always_comb begin
    sel_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (way_hit[i]) sel_way = WAY_W'(i);
    end
  end

  assign any_hit = |way_hit;
  assign sel_lo  = rd_lo[sel_way];
endmodule

// File: rtl/tlb_classify.sv
module tlb_classify (
  input  logic       valid,
  input  logic       any_hit,
  input  logic [1:0] pr,
  input  logic       dirty,
  input  logic       wr,
  input  logic       priv,
  output logic       o_hit,
  output logic       o_miss,
  output logic       o_prot,
  output logic       o_ipw
);
  import tlb_pkg::*;

  logic ok_rights, first_wr;
  assign ok_rights = rights_permit(pr, priv, wr);
  assign first_wr  = needs_first_write(wr, dirty);

  // priority: miss, then protection, then first-write, then hit
  assign o_miss = valid & ~any_hit;
  assign o_prot = valid & any_hit & ~ok_rights;
  assign o_ipw  = valid & any_hit & ok_rights & first_wr;
  assign o_hit  = valid & any_hit & ok_rights & ~first_wr;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int WAYS   = 4,
  parameter int SETS   = 32,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PPN_W  = 20,
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = $clog2(SETS),
  localparam int HI_W  = VPN_W + ASID_W,
  localparam int LO_W  = PPN_W + tlb_pkg::LO_ATTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [WAY_W-1:0]  ld_way,
  input  logic [HI_W-1:0]   ld_hi,
  input  logic [LO_W-1:0]   ld_lo,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  input  logic              lk_priv,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_prot,
  output logic              res_ipw,
  output logic [WAY_W-1:0]  res_way,
  output logic [PPN_W-1:0]  res_ppn,
  output logic              res_size,
  output logic              res_cache
);
  import tlb_pkg::*;

  logic [WAYS-1:0][HI_W-1:0] rd_hi;
  logic [WAYS-1:0][LO_W-1:0] rd_lo;
  logic [IDX_W-1:0]          wr_idx, rd_idx;

  // named internal events for the checker
  logic [WAYS-1:0]  way_hit;
  logic             any_hit;
  logic [WAY_W-1:0] sel_way;
  logic [LO_W-1:0]  sel_lo;
  logic [1:0]       sel_pr;
  logic             sel_dirty;

  assign wr_idx = ld_hi[ASID_W +: IDX_W];
  assign rd_idx = lk_vpn[IDX_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tlb_way #(.SETS(SETS), .HI_W(HI_W), .LO_W(LO_W)) way_i (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (ld_en && (ld_way == WAY_W'(w))),
      .widx (wr_idx),
      .whi  (ld_hi),
      .wlo  (ld_lo),
      .ridx (rd_idx),
      .rhi  (rd_hi[w]),
      .rlo  (rd_lo[w])
    );
  end

  tlb_match #(.WAYS(WAYS), .VPN_W(VPN_W), .ASID_W(ASID_W), .LO_W(LO_W)) match_i (
    .rd_hi  (rd_hi),
    .rd_lo  (rd_lo),
    .q_vpn  (lk_vpn),
    .q_asid (lk_asid),
    .way_hit(way_hit),
    .any_hit(any_hit),
    .sel_way(sel_way),
    .sel_lo (sel_lo)
  );

  assign sel_pr    = sel_lo[LO_PR_LO +: 2];
  assign sel_dirty = sel_lo[LO_DIRTY];

  tlb_classify class_i (
    .valid  (lk_valid),
    .any_hit(any_hit),
    .pr     (sel_pr),
    .dirty  (sel_dirty),
    .wr     (lk_write),
    .priv   (lk_priv),
    .o_hit  (res_hit),
    .o_miss (res_miss),
    .o_prot (res_prot),
    .o_ipw  (res_ipw)
  );

  assign res_way   = (res_hit | res_prot | res_ipw) ? sel_way : '0;
  assign res_ppn   = res_hit ? sel_lo[LO_W-1:LO_ATTR_W] : '0;
  assign res_size  = res_hit & sel_lo[LO_SIZE];
  assign res_cache = res_hit & sel_lo[LO_CACHE];
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_write,
  input logic             lk_priv,
  input logic             res_hit,
  input logic             res_miss,
  input logic             res_prot,
  input logic             res_ipw,
  input logic [WAY_W-1:0] res_way,
  input logic [WAYS-1:0]  way_hit,
  input logic [1:0]       sel_pr,
  input logic             sel_dirty
);
  logic [3:0]      flags;
  logic [WAYS-1:0] below_mask;
  assign flags      = {res_hit, res_miss, res_prot, res_ipw};
  assign below_mask = ~({WAYS{1'b1}} << res_way);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags)); // R10
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> flags == 4'b0000); // R10
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones(flags) == 1); // R10
  AST_MISS_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> way_hit == '0); // R4
  AST_WAY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit | res_ipw | res_prot) |-> way_hit[res_way]); // R3
  AST_LOWEST_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit | res_ipw | res_prot) |-> (way_hit & below_mask) == '0); // R11
  AST_IPW_CLEAN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    res_ipw |-> (lk_write && !sel_dirty)); // R7
  AST_USER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((res_hit | res_ipw) && !lk_priv) |-> sel_pr[1]); // R6
  AST_PROT_BEFORE_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ipw || (res_hit && lk_write)) |-> sel_pr[0]); // R8
endmodule

bind tlb_xlate tlb_xlate_chk #(.WAYS(WAYS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_write (lk_write),
  .lk_priv  (lk_priv),
  .res_hit  (res_hit),
  .res_miss (res_miss),
  .res_prot (res_prot),
  .res_ipw  (res_ipw),
  .res_way  (res_way),
  .way_hit  (way_hit),
  .sel_pr   (sel_pr),
  .sel_dirty(sel_dirty)
);

// File: tb/tlb_xlate_tb_top.sv
`timescale 1ns/1ps
module tlb_xlate_tb_top;
  localparam int NW = 4;
  localparam int NS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_way = '0;
  logic [27:0] ld_hi = '0;
  logic [26:0] ld_lo = '0;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_write = 1'b0;
  logic        lk_priv = 1'b0;
  logic        res_hit, res_miss, res_prot, res_ipw;
  logic [1:0]  res_way;
  logic [19:0] res_ppn;
  logic        res_size, res_cache;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model of the array contents
  logic [19:0] m_vpn [NW][NS];
  logic [7:0]  m_asid[NW][NS];
  logic [19:0] m_ppn [NW][NS];
  logic [1:0]  m_pr  [NW][NS];
  logic        m_sz[NW][NS], m_c[NW][NS], m_d[NW][NS], m_sh[NW][NS], m_v[NW][NS];

  always #2 clk = ~clk;

  tlb_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_way(ld_way), .ld_hi(ld_hi),
    .ld_lo(ld_lo), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_write(lk_write), .lk_priv(lk_priv), .res_hit(res_hit),
    .res_miss(res_miss), .res_prot(res_prot), .res_ipw(res_ipw),
    .res_way(res_way), .res_ppn(res_ppn), .res_size(res_size),
    .res_cache(res_cache)
  );

  task automatic load(input int w, input logic [19:0] vpn, input logic [7:0] asid,
                      input logic [19:0] ppn, input logic [1:0] pr, input logic sz,
                      input logic c, input logic d, input logic sh, input logic v);
    int s;
    s = int'(vpn[4:0]);
    @(negedge clk);
    ld_en  = 1'b1;
    ld_way = 2'(w);
    ld_hi  = {vpn, asid};
    ld_lo  = {ppn, pr, sz, c, d, sh, v};
    @(negedge clk);
    ld_en  = 1'b0;
    m_vpn[w][s] = vpn; m_asid[w][s] = asid; m_ppn[w][s] = ppn; m_pr[w][s] = pr;
    m_sz[w][s] = sz; m_c[w][s] = c; m_d[w][s] = d; m_sh[w][s] = sh; m_v[w][s] = v;
  endtask

  // expected flags {hit, miss, prot, ipw}
  task automatic lookup(input logic [19:0] vpn, input logic [7:0] asid,
                        input logic wr, input logic priv, input logic en,
                        input string req);
    int s, fw;
    logic [3:0]  ef;
    logic [1:0]  ew;
    logic [19:0] ep;
    logic        esz, ec, user_ok, write_ok;
    s = int'(vpn[4:0]);
    fw = -1;
    for (int w = NW - 1; w >= 0; w--) begin
      if (m_v[w][s] && m_vpn[w][s] == vpn && (m_sh[w][s] || m_asid[w][s] == asid))
        fw = w;
    end
    ef = 4'b0000; ew = '0; ep = '0; esz = 1'b0; ec = 1'b0;
    if (en) begin
      if (fw < 0) ef = 4'b0100;
      else begin
        user_ok  = m_pr[fw][s] >= 2'd2;
        write_ok = m_pr[fw][s] == 2'd1 || m_pr[fw][s] == 2'd3;
        ew = 2'(fw);
        if ((!priv && !user_ok) || (wr && !write_ok)) ef = 4'b0010;
        else if (wr && !m_d[fw][s]) ef = 4'b0001;
        else begin
          ef = 4'b1000; ep = m_ppn[fw][s]; esz = m_sz[fw][s]; ec = m_c[fw][s];
        end
      end
    end
    @(negedge clk);
    lk_valid = en; lk_vpn = vpn; lk_asid = asid; lk_write = wr; lk_priv = priv;
    #1;
    total++;
    if ({res_hit, res_miss, res_prot, res_ipw} !== ef || res_way !== ew ||
        res_ppn !== ep || res_size !== esz || res_cache !== ec) begin
      bad++;
      $display("FAIL %s: vpn=%h wr=%0b priv=%0b got flags=%b way=%0d ppn=%h sz=%0b c=%0b exp flags=%b way=%0d ppn=%h sz=%0b c=%0b",
               req, vpn, wr, priv, {res_hit, res_miss, res_prot, res_ipw}, res_way,
               res_ppn, res_size, res_cache, ef, ew, ep, esz, ec);
    end
  endtask

  function automatic logic [19:0] vpn_of(input int w, input int s);
    return {15'((w + 1) * 1000 + s * 3), 5'(s)};
  endfunction

  function automatic string req_of(input logic wr, input logic priv, input int w,
                                   input int s);
    logic [1:0] pr;
    pr = m_pr[w][s];
    if (!m_v[w][s]) return "R4";
    if (!priv && !pr[1]) return "R6";
    if (wr && !pr[0]) return m_d[w][s] ? "R6" : "R8";
    if (wr && !m_d[w][s]) return "R7";
    return "R3";
  endfunction

  initial begin
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++) m_v[w][s] = 1'b0;
    // R10: outputs quiet during reset with no request
    repeat (3) @(negedge clk);
    lookup(20'h00000, 8'h00, 1'b0, 1'b1, 1'b0, "R10");
    rst_n = 1'b1;
    // R1: every set misses after reset
    for (int s = 0; s < NS; s++) lookup(vpn_of(0, s), 8'h00, 1'b0, 1'b1, 1'b1, "R1");
    // R2: fill every set of every way
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++)
        load(w, vpn_of(w, s), 8'(w * 16 + s), 20'(w * 4096 + s * 17 + 5),
             2'((s + w) % 4), 1'(s), 1'(w), 1'(s >> 2), 1'((s >> 3) ^ w),
             1'(s % 7 != 6));
    // R3, R6, R7, R8: all access kinds on every entry
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++)
        for (int k = 0; k < 4; k++)
          lookup(vpn_of(w, s), 8'(w * 16 + s), 1'(k), 1'(k >> 1), 1'b1,
                 req_of(1'(k), 1'(k >> 1), w, s));
    // R5: wrong ASID hits only shared entries
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++)
        lookup(vpn_of(w, s), 8'(w * 16 + s + 1), 1'b0, 1'b1, 1'b1, "R5");
    // R4: page numbers absent from the array
    for (int s = 0; s < NS; s += 5) lookup({15'h7fff, 5'(s)}, 8'h00, 1'b1, 1'b0, 1'b1, "R4");
    // R11: same page in ways 2 and 1, then way 0
    load(2, 20'hABCD3, 8'h11, 20'h22222, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    load(1, 20'hABCD3, 8'h11, 20'h11111, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    lookup(20'hABCD3, 8'h11, 1'b1, 1'b0, 1'b1, "R11");
    load(0, 20'hABCD3, 8'h11, 20'h00F00, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    lookup(20'hABCD3, 8'h11, 1'b1, 1'b0, 1'b1, "R11");
    lookup(20'hABCD3, 8'h11, 1'b0, 1'b0, 1'b1, "R11");
    // R9: invalidating way 0 exposes way 1; the old entry of way 3 set 3 remains
    load(0, 20'hABCD3, 8'h11, 20'h00F00, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    lookup(20'hABCD3, 8'h11, 1'b0, 1'b0, 1'b1, "R9");
    lookup(vpn_of(3, 3), 8'(3 * 16 + 3), 1'b0, 1'b1, 1'b1, "R9");
    lookup(vpn_of(0, 3), 8'(3), 1'b0, 1'b1, 1'b1, "R9");
    for (int w = 0; w < NW; w++) lookup(vpn_of(w, 4), 8'(w * 16 + 4), 1'b0, 1'b1, 1'b1, "R9");
    // R10: matching address without a request stays quiet
    lookup(20'hABCD3, 8'h11, 1'b1, 1'b1, 1'b0, "R10");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule